// File: doc/BRIEF.md
# Pulse-Width Modulator with Queued Duty Samples

This block drives one pulse-width-modulated output from a register-programmed counter. Software sets a period length and pushes duty values into a four-entry queue. The counter consumes exactly one queued value per output period. Queuing lets software stay ahead of the waveform: it can load several future duty values without racing the counter.

A 12-bit divider slows the input clock to a counter tick. A 16-bit period value sets the cycle length. Each period starts high and falls once the tick count reaches the active duty value. If the queue is empty at a boundary, the last duty value is used again.

A control bit starts a short self-clearing reset. It empties the queue, stops the counter and zeroes the control fields. A status word reports how many queue slots are in use, and carries a sticky flag for writes lost because the queue was full. The bus is a simple one-cycle write strobe with a combinational read port.

Top module: `pwm_fifo_gen`

## Requirements
- R1: After the reset input is released, all four registers read 0 and `pwm_out` is low. The registers are control at address 0x00, status at 0x04, duty at 0x0C and period at 0x10.
- R2: The control register keeps the following bits and reads them back; every other bit reads 0:
  - bit 0: run enable
  - bits 15:4: divider, written as ratio minus one
  - bits 17:16: clock select
  - bits 24:22: three retained flags with no effect
- R3: Status bits 2:0 give the number of queued duty values, from 0 to 4. A value of 4 means the queue is full.
- R4: A duty write while the queue holds 4 entries is discarded and sets status bit 4. Bit 4 stays set until software writes 1 to it.
- R5: One output period lasts period-register + 2 ticks. The output is high for the first min(d, period+2) ticks, where d is the active duty value. A duty of 0 keeps the output low for the whole period.
- R6: Queued duty values become active in write order, one per period boundary. When the queue is empty at a boundary, the previous value stays active. The duty address reads back the active value.
- R7: A duty value written during a period never changes that period's waveform.
- R8: A divider field of p makes each tick last p+1 input clocks.
- R9: The first period begins on the clock after the enable bit is set, and it takes the queue head at that point. The cycle after the enable bit is cleared, the output is forced low and the counter stops.
- R10: Writing control with bit 3 set starts a reset:
  - It clears the queue, the counter, the active duty value, the overflow flag and all control fields.
  - Bit 3 then reads 1 for exactly 4 clocks.
  - While bit 3 reads 1, writes to any address other than control are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the counter source |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pwm_out | output | 1 | Modulated output |

## Verification
The embedded properties assume that the bus strobes at most one write per clock. They also assume that the period register is not rewritten while a period is under way. With that held, the active duty value is stable between boundaries, and the queue is empty and the counter idle for as long as the reset countdown runs. The stimulus changes the period register only while the counter is disabled. It issues writes in separate clocks, so each property sees a single well-defined access.

// File: rtl/pwm_fifo_gen.sv
module pwm_fifo_gen #(
  parameter int CW    = 16,
  parameter int PW    = 12,
  parameter int DEPTH = 4,
  parameter int AW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          pwm_out
);
  localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);
  localparam logic [CNTW-1:0] FULL = CNTW'(DEPTH);
  localparam logic [31:0] CTL_KEEP = 32'h01C3_0001 | (((32'd1 << PW) - 32'd1) << 4);
  localparam logic [AW-1:0] A_CTL = AW'(5'h00);
  localparam logic [AW-1:0] A_STA = AW'(5'h04);
  localparam logic [AW-1:0] A_DTY = AW'(5'h0C);
  localparam logic [AW-1:0] A_PER = AW'(5'h10);
  localparam logic [2:0] SRST_CYC = 3'd4;

  logic [31:0]     ctl_q;
  logic [2:0]      rst_left;
  logic [CW-1:0]   span_q, active;
  logic [CW-1:0]   mem [DEPTH];
  logic [PTRW-1:0] wp, rp;
  logic [CNTW-1:0] fcnt;
  logic            ovf, run;
  logic [PW-1:0]   pre;
  logic [CW:0]     cnt;

  wire busy    = rst_left != 3'd0;
  wire wr_ok   = bus_wr && !busy;
  wire srst_go = bus_wr && bus_addr == A_CTL && bus_wdata[3];
  wire clr     = srst_go || busy;
  wire en      = ctl_q[0];
  wire tick    = run && pre == ctl_q[PW+3:4];
  wire [CW:0] last = {1'b0, span_q} + 1'b1;
  wire wrap    = tick && cnt >= last;
  wire start   = en && !run && !busy;
  wire bnd     = start || wrap;
  wire full    = fcnt == FULL;
  wire dty_wr  = wr_ok && bus_addr == A_DTY;
  wire push    = dty_wr && !full;
  wire pop     = bnd && fcnt != '0;

  assign pwm_out = run && cnt < {1'b0, active};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q    <= '0;
      rst_left <= '0;
    end else begin
      if (srst_go) ctl_q <= '0;
      else if (bus_wr && bus_addr == A_CTL) ctl_q <= bus_wdata & CTL_KEEP;
      if (srst_go) rst_left <= SRST_CYC;
      else if (busy) rst_left <= rst_left - 3'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) span_q <= '0;
    else if (wr_ok && bus_addr == A_PER) span_q <= bus_wdata[CW-1:0];
  end

  always_ff @(posedge clk) if (push) mem[wp] <= bus_wdata[CW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; fcnt <= '0; ovf <= 1'b0;
    end else if (clr) begin
      wp <= '0; rp <= '0; fcnt <= '0; ovf <= 1'b0;
    end else begin
      if (push) wp <= (wp == PTRW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == PTRW'(DEPTH-1)) ? '0 : rp + 1'b1;
      fcnt <= fcnt + CNTW'(push) - CNTW'(pop);
      if (dty_wr && full) ovf <= 1'b1;
      else if (wr_ok && bus_addr == A_STA && bus_wdata[4]) ovf <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; pre <= '0; cnt <= '0; active <= '0;
    end else if (clr || !en) begin
      run <= 1'b0; pre <= '0; cnt <= '0;
      if (clr) active <= '0;
    end else begin
      run <= 1'b1;
      if (start) begin
        pre <= '0; cnt <= '0;
      end else begin
        pre <= tick ? '0 : pre + 1'b1;
        if (tick) cnt <= wrap ? '0 : cnt + 1'b1;
      end
      if (pop) active <= mem[rp];
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTL:   bus_rdata = ctl_q | {28'd0, busy, 3'd0};
      A_STA:   bus_rdata = 32'(fcnt) | (32'(ovf) << 4);
      A_DTY:   bus_rdata = 32'(active);
      A_PER:   bus_rdata = 32'(span_q);
      default: bus_rdata = '0;
    endcase
  end

  p_fifo_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fcnt <= FULL);
  p_drop_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_DTY && !busy && full) |=> ovf);
  p_zero_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (active == '0) |-> !pwm_out);
  p_hold_mid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !bnd && !srst_go) |=> $stable(active));
  p_reset_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (fcnt == '0 && !run));
endmodule

// File: tb/pwm_fifo_gen_tb_top.sv
module pwm_fifo_gen_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic pwm_out;
  int checks = 0, fails = 0;
  bit watch = 1'b0, done = 1'b0;
  bit exp_q[$];
  string mon_tag = "R5";

  always #4 clk = ~clk;

  pwm_fifo_gen dut_i (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
                      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out));

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1 bus_wr = 1'b0;
  endtask

  task automatic rd_chk(logic [4:0] a, logic [31:0] exp, string tag);
    @(negedge clk); bus_addr = a; #1;
    chk(bus_rdata == exp, tag, bus_rdata, exp);
  endtask

  task automatic push_period(int d, int span, int presc);
    for (int t = 0; t < span + 2; t++)
      for (int k = 0; k <= presc; k++) exp_q.push_back(t < d);
  endtask

  task automatic run_from(logic [31:0] c, string tag);
    mon_tag = tag;
    wr(5'h00, c);
    @(posedge clk);
    watch = 1'b1;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(posedge clk);
    watch = 1'b0;
  endtask

  task automatic soft_reset();
    wr(5'h00, 32'h8);
    repeat (5) @(posedge clk);
  endtask

  always @(negedge clk) begin
    if (watch && exp_q.size() > 0) begin
      bit e;
      e = exp_q.pop_front();
      chk(pwm_out == e, mon_tag, 32'(pwm_out), 32'(e));
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    rd_chk(5'h00, 0, "R1 ctl");
    rd_chk(5'h04, 0, "R1 status");
    rd_chk(5'h0C, 0, "R1 duty");
    rd_chk(5'h10, 0, "R1 period");
    chk(pwm_out == 1'b0, "R1 out", 32'(pwm_out), 0);

    // R3 / R4 queue fill and overflow
    wr(5'h10, 4);
    wr(5'h0C, 2); wr(5'h0C, 0);
    rd_chk(5'h04, 2, "R3 half");
    wr(5'h0C, 7); wr(5'h0C, 3);
    rd_chk(5'h04, 4, "R3 full");
    wr(5'h0C, 5);
    rd_chk(5'h04, 32'h14, "R4 drop sets flag");
    wr(5'h04, 32'h10);
    rd_chk(5'h04, 4, "R4 flag cleared");

    // R5 / R6 order, zero, above-period, reuse, dropped value absent
    push_period(2, 4, 0); push_period(0, 4, 0); push_period(7, 4, 0);
    push_period(3, 4, 0); push_period(3, 4, 0);
    run_from(32'h1, "R5_R6 stream");
    drain();
    wr(5'h00, 0);
    @(posedge clk); @(negedge clk);
    chk(pwm_out == 1'b0, "R9 disable low", 32'(pwm_out), 0);
    repeat (3) @(negedge clk);
    chk(pwm_out == 1'b0, "R9 stays low", 32'(pwm_out), 0);
    rd_chk(5'h04, 0, "R6 all consumed");
    rd_chk(5'h0C, 3, "R6 last reused");

    // R7 mid-period write waits for the boundary
    soft_reset();
    wr(5'h0C, 2);
    push_period(2, 4, 0); push_period(4, 4, 0); push_period(4, 4, 0);
    run_from(32'h1, "R7 boundary");
    @(posedge clk); @(posedge clk);
    wr(5'h0C, 4);
    drain();

    // R8 divider and R2 field retention
    soft_reset();
    wr(5'h10, 1);
    wr(5'h0C, 1);
    push_period(1, 1, 2); push_period(1, 1, 2);
    run_from(32'h01C2_0021 | 32'h8000_0004, "R8 divider");
    drain();
    rd_chk(5'h00, 32'h01C2_0021, "R2 readback");

    // R10 self-clearing reset
    wr(5'h00, 32'h8);
    rd_chk(5'h00, 32'h8, "R10 busy clears fields");
    wr(5'h0C, 9);
    rd_chk(5'h00, 32'h8, "R10 busy 2");
    rd_chk(5'h00, 32'h8, "R10 busy 3");
    rd_chk(5'h00, 0, "R10 done after 4 clocks");
    rd_chk(5'h04, 0, "R10 write ignored, queue empty");
    rd_chk(5'h0C, 0, "R10 active cleared");
    chk(pwm_out == 1'b0, "R10 out low", 32'(pwm_out), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule